// File: doc/BRIEF.md
# Edge-Pulse Level Link with Refresh and Watchdog

This block sends one logic level over a link that carries only pulses, as needed across an isolation barrier. The link is two single-bit lines, one for "set" and one for "reset". The transmit half watches an input bit. It sends a set pulse when the bit goes high and a reset pulse when it goes low. While the bit stays still, it repeats a pulse of the matching kind at a fixed period. That refresh keeps the far side correct even for a level that never changes.

The receive half is a bistable latch: a set pulse makes its output high and a reset pulse makes it low. A watchdog counts the cycles since the last pulse of either kind. When that count reaches its timeout, the receiver decides the transmit side is dead and drops its output to the safe low level. The output then stays low until a set pulse arrives.

The two halves sit in one top module but are not wired together inside it. The integrator, or a bench, closes the link between `tx_set_o`/`tx_rst_o` and `rx_set_i`/`rx_rst_i`.

Top module: `edge_pulse_link`

## Requirements
- R1: On the first clock edge at which `tx_din` is sampled high after being sampled low, `tx_set_o` becomes 1 and stays 1 for PULSE_W cycles, while `tx_rst_o` stays 0. The two transmit lines are never high together.
- R2: On the first clock edge at which `tx_din` is sampled low after being sampled high, `tx_rst_o` becomes 1 for PULSE_W cycles, while `tx_set_o` stays 0.
- R3: A cycle with `rx_set_i`=1 and `rx_rst_i`=0 makes `rx_dout` 1 from the next cycle on. A cycle with `rx_rst_i`=1 makes `rx_dout` 0 from the next cycle on. With neither line high, `rx_dout` keeps its value, unless the watchdog acts (R5).
- R4: While `tx_din` is unchanged, a refresh pulse starts REFRESH_CYC cycles after the start of the previous pulse. The refresh pulse is on `tx_set_o` if the level is 1 and on `tx_rst_o` if it is 0, and it repeats every REFRESH_CYC cycles. A real edge restarts this spacing.
- R5: If neither receive line is high for WDOG_CYC consecutive sampled cycles, `rx_dout` is 0 in the cycle after the last of them.
- R6: WDOG_CYC must exceed REFRESH_CYC, and this is checked at elaboration. With the link closed and the input held at 1 for several timeout spans, `rx_dout` never drops.
- R7: After a watchdog timeout, reset pulses keep `rx_dout` at 0. Only a set pulse brings it back to 1.
- R8: If both receive lines are high in the same cycle, `rx_dout` goes to 0. `rx_err` then goes to 1 and stays 1 until reset.
- R9: Synchronous active-high `rst` produces this state: both transmit lines low, the remembered input level low, the refresh timer at zero, `rx_dout` 0, the watchdog expired and `rx_err` 0. If `tx_din` stays 0 after reset, the first reset pulse comes REFRESH_CYC cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| tx_din | input | 1 | Level to be carried across the link |
| tx_set_o | output | 1 | Transmit set-pulse line |
| tx_rst_o | output | 1 | Transmit reset-pulse line |
| rx_set_i | input | 1 | Received set-pulse line |
| rx_rst_i | input | 1 | Received reset-pulse line |
| rx_dout | output | 1 | Recovered level; 0 after a watchdog timeout |
| rx_err | output | 1 | Sticky flag: set and reset were seen in the same cycle |

## Verification
The bench counts the exact cycle of the first refresh pulse after an edge. An off-by-one timer, or one that an edge does not restart, shows up as a refresh pulse in the wrong cycle. It cuts the link straight after a set pulse and checks that the output drops in exactly the timeout cycle. A watchdog that never clears, or that counts from the wrong point, drops the output too early or too late. After a timeout it sends only reset refresh pulses and checks that the output stays low, then recovers on a set pulse. It also forces set and reset together, where a design that lets set win would leave the output high. Long random runs, with partial and full link cuts, compare every cycle against a model the bench computes.

// File: rtl/epl_pkg.sv
package epl_pkg;

    // Kind of pulse currently driven by the transmitter
    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_SET  = 2'd1,
        PK_RST  = 2'd2
    } pulse_kind_e;

endpackage

// File: rtl/epl_tx.sv
module epl_tx
    import epl_pkg::*;
#(
    parameter int REFRESH_CYC = 100,
    parameter int PULSE_W     = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic set_o,
    output logic rst_o
);

    localparam int IW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
    localparam int LW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
    localparam logic [IW-1:0] IDLE_LAST = IW'(REFRESH_CYC - 1);
    localparam logic [LW-1:0] LEFT_INIT = LW'(PULSE_W - 1);

    typedef struct packed {
        logic          prev;
        logic [IW-1:0] idle;
        logic [LW-1:0] left;
        pulse_kind_e   kind;
    } tx_state_t;

    tx_state_t st_d, st_q;
    pulse_kind_e start;

    always_comb begin
        st_d  = st_q;
        start = PK_NONE;

        // edge detection takes priority over the idle refresh
        if (din != st_q.prev) begin
            start     = din ? PK_SET : PK_RST;
            st_d.idle = '0;
        end else if (st_q.idle == IDLE_LAST) begin
            start     = st_q.prev ? PK_SET : PK_RST;
            st_d.idle = '0;
        end else begin
            st_d.idle = st_q.idle + IW'(1);
        end
        st_d.prev = din;

        // pulse shaping
        if (start != PK_NONE) begin
            st_d.kind = start;
            st_d.left = LEFT_INIT;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - LW'(1);
        end else begin
            st_d.kind = PK_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.prev <= 1'b0;
            st_q.idle <= '0;
            st_q.left <= '0;
            st_q.kind <= PK_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign set_o = (st_q.kind == PK_SET);
    assign rst_o = (st_q.kind == PK_RST);

endmodule

// File: rtl/epl_rx.sv
module epl_rx #(
    parameter int WDOG_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rst_i,
    output logic dout,
    output logic err
);

    localparam int WW = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;
    localparam logic [WW-1:0] WD_LAST = WW'(WDOG_CYC - 1);

    typedef struct packed {
        logic          dout;
        logic          expired;
        logic          err;
        logic [WW-1:0] cnt;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i || rst_i) begin
            // any pulse proves the far side alive; reset dominates set
            st_d.cnt     = '0;
            st_d.expired = 1'b0;
            st_d.dout    = !rst_i;
            if (set_i && rst_i) begin
                st_d.err = 1'b1;
            end
        end else if (!st_q.expired) begin
            if (st_q.cnt == WD_LAST) begin
                st_d.expired = 1'b1;
                st_d.dout    = 1'b0;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = st_q.cnt + WW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dout    <= 1'b0;
            st_q.expired <= 1'b1;
            st_q.err     <= 1'b0;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;
    assign err  = st_q.err;

endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link #(
    parameter int REFRESH_CYC = 100,
    parameter int WDOG_CYC    = 500,
    parameter int PULSE_W     = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_din,
    output logic tx_set_o,
    output logic tx_rst_o,
    input  logic rx_set_i,
    input  logic rx_rst_i,
    output logic rx_dout,
    output logic rx_err
);

    // R6: a healthy idle link must refresh before the watchdog trips
    if (WDOG_CYC <= REFRESH_CYC) begin : g_bad_wdog
        $error("WDOG_CYC must exceed REFRESH_CYC");
    end
    if (PULSE_W < 1 || PULSE_W >= REFRESH_CYC || REFRESH_CYC < 2) begin : g_bad_pulse
        $error("PULSE_W must be at least 1 and below REFRESH_CYC");
    end

    epl_tx #(
        .REFRESH_CYC(REFRESH_CYC),
        .PULSE_W    (PULSE_W)
    ) u_tx (
        .clk  (clk),
        .rst  (rst),
        .din  (tx_din),
        .set_o(tx_set_o),
        .rst_o(tx_rst_o)
    );

    epl_rx #(
        .WDOG_CYC(WDOG_CYC)
    ) u_rx (
        .clk  (clk),
        .rst  (rst),
        .set_i(rx_set_i),
        .rst_i(rx_rst_i),
        .dout (rx_dout),
        .err  (rx_err)
    );

endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
    parameter int WDOG_CYC = 500
) (
    input logic clk,
    input logic rst,
    input logic tx_din,
    input logic tx_set_o,
    input logic tx_rst_o,
    input logic rx_set_i,
    input logic rx_rst_i,
    input logic rx_dout,
    input logic rx_err
);

    localparam int QW = $clog2(WDOG_CYC + 1);

    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet <= QW'(WDOG_CYC);
        end else if (rx_set_i || rx_rst_i) begin
            quiet <= '0;
        end else if (quiet != QW'(WDOG_CYC)) begin
            quiet <= quiet + QW'(1);
        end
    end

    // R1
    set_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_din) |=> tx_set_o && !tx_rst_o);

    // R2
    rst_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_din) |=> tx_rst_o && !tx_set_o);

    // R1
    lines_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_set_o && tx_rst_o));

    // R3
    rx_set_high_chk: assert property (@(posedge clk) disable iff (rst)
        rx_set_i && !rx_rst_i |=> rx_dout);

    // R3
    rx_rst_low_chk: assert property (@(posedge clk) disable iff (rst)
        rx_rst_i |=> !rx_dout);

    // R7
    no_rise_without_set_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_set_i && !rx_dout |=> !rx_dout);

    // R5
    wdog_low_chk: assert property (@(posedge clk) disable iff (rst)
        (quiet == QW'(WDOG_CYC)) |-> !rx_dout);

    // R8
    collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rx_set_i && rx_rst_i |=> rx_err && !rx_dout);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |=> rx_err);

endmodule

bind edge_pulse_link epl_checker #(.WDOG_CYC(WDOG_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_din  (tx_din),
    .tx_set_o(tx_set_o),
    .tx_rst_o(tx_rst_o),
    .rx_set_i(rx_set_i),
    .rx_rst_i(rx_rst_i),
    .rx_dout (rx_dout),
    .rx_err  (rx_err)
);

// File: tb/tb_edge_pulse_link.sv
module tb_edge_pulse_link;

    localparam int CLK_PERIOD  = 10;
    localparam int REFRESH_CYC = 100;
    localparam int WDOG_CYC    = 500;
    localparam int PULSE_W     = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic cut = 1'b0;
    logic inj_s = 1'b0;
    logic inj_r = 1'b0;
    logic tx_set_o, tx_rst_o, rx_set_i, rx_rst_i, rx_dout, rx_err;

    int checks = 0;
    int errors = 0;

    // bench model state
    int m_prev, m_idle, m_kind, m_left;
    int m_dout, m_exp, m_cnt, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_set_i = (tx_set_o & ~cut) | inj_s;
    assign rx_rst_i = (tx_rst_o & ~cut) | inj_r;

    edge_pulse_link #(
        .REFRESH_CYC(REFRESH_CYC),
        .WDOG_CYC   (WDOG_CYC),
        .PULSE_W    (PULSE_W)
    ) dut (
        .clk     (clk),
        .rst     (rst),
        .tx_din  (din),
        .tx_set_o(tx_set_o),
        .tx_rst_o(tx_rst_o),
        .rx_set_i(rx_set_i),
        .rx_rst_i(rx_rst_i),
        .rx_dout (rx_dout),
        .rx_err  (rx_err)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the bench model by one clock using the current inputs
    task automatic model_step();
        int lset, lrst, start;
        lset = ((m_kind == 1) && !cut) || inj_s;
        lrst = ((m_kind == 2) && !cut) || inj_r;
        if (rst) begin
            m_prev = 0; m_idle = 0; m_kind = 0; m_left = 0;
            m_dout = 0; m_exp = 1; m_cnt = 0; m_err = 0;
        end else begin
            start = 0;
            if (int'(din) != m_prev) begin
                start = din ? 1 : 2;
                m_idle = 0;
            end else if (m_idle == REFRESH_CYC - 1) begin
                start = (m_prev != 0) ? 1 : 2;
                m_idle = 0;
            end else begin
                m_idle++;
            end
            m_prev = int'(din);
            if (start != 0) begin
                m_kind = start;
                m_left = PULSE_W - 1;
            end else if (m_left != 0) begin
                m_left--;
            end else begin
                m_kind = 0;
            end
            if (lset || lrst) begin
                m_cnt = 0;
                m_exp = 0;
                m_dout = lrst ? 0 : 1;
                if (lset && lrst) m_err = 1;
            end else if (m_exp == 0) begin
                if (m_cnt == WDOG_CYC - 1) begin
                    m_exp = 1; m_dout = 0; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R1/R4 set line", tx_set_o, logic'(m_kind == 1));
        chk("R2/R4 reset line", tx_rst_o, logic'(m_kind == 2));
        chk("R3/R5/R7 output", rx_dout, logic'(m_dout));
        chk("R8 error flag", rx_err, logic'(m_err));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        int first;
        int low_seen;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        tick();
        tick();
        // R9: reset state
        chk("R9 set low", tx_set_o, 1'b0);
        chk("R9 reset low", tx_rst_o, 1'b0);
        chk("R9 dout low", rx_dout, 1'b0);
        chk("R9 err low", rx_err, 1'b0);
        rst = 1'b0;

        // R9: first reset refresh pulse after REFRESH_CYC cycles
        first = 0;
        for (int k = 1; k <= REFRESH_CYC + 2; k++) begin
            tick();
            if (tx_rst_o && first == 0) first = k;
        end
        chk_int("R9 first refresh after reset", first, REFRESH_CYC);

        // R1: rising edge
        din = 1'b1;
        tick();
        chk("R1 set pulse on rise", tx_set_o, 1'b1);
        chk("R1 no reset pulse on rise", tx_rst_o, 1'b0);
        tick();
        chk("R1 pulse width", tx_set_o, 1'b0);
        chk("R3 output follows set", rx_dout, 1'b1);

        // R4: refresh at high level, spacing from edge pulse
        first = 0;
        for (int k = 2; k <= REFRESH_CYC + 2; k++) begin
            tick();
            if (tx_set_o && first == 0) first = k;
        end
        chk_int("R4 high refresh spacing", first, REFRESH_CYC);

        // R6: healthy idle high link never drops
        low_seen = 0;
        for (int k = 0; k < 3 * WDOG_CYC; k++) begin
            tick();
            if (!rx_dout) low_seen = 1;
        end
        chk_int("R6 idle high link holds", low_seen, 0);

        // R5: cut right after a set pulse, measure drop
        while (!tx_set_o) tick();
        tick();
        cut = 1'b1;
        first = 0;
        for (int k = 1; k <= WDOG_CYC + 3; k++) begin
            tick();
            if (!rx_dout && first == 0) first = k;
        end
        chk_int("R5 timeout cycle", first, WDOG_CYC);

        // R2 / R7: fall while cut, then only reset pulses arrive
        din = 1'b0;
        tick();
        chk("R2 reset pulse on fall", tx_rst_o, 1'b1);
        chk("R2 no set pulse on fall", tx_set_o, 1'b0);
        cut = 1'b0;
        low_seen = 1;
        for (int k = 0; k < 3 * REFRESH_CYC; k++) begin
            tick();
            if (rx_dout) low_seen = 0;
        end
        chk_int("R7 stays low on reset pulses", low_seen, 1);
        din = 1'b1;
        tick();
        tick();
        chk("R7 recovers on set", rx_dout, 1'b1);

        // R8: collision, reset wins and error sticks
        inj_s = 1'b1;
        inj_r = 1'b1;
        tick();
        inj_s = 1'b0;
        inj_r = 1'b0;
        chk("R8 reset wins", rx_dout, 1'b0);
        chk("R8 error set", rx_err, 1'b1);
        for (int k = 0; k < 5; k++) tick();
        chk("R8 error sticky", rx_err, 1'b1);

        // random phase against the model
        for (int seg = 0; seg < 120; seg++) begin
            int len;
            len = ($urandom % 4 == 0) ? 150 + int'($urandom % 700) : 1 + int'($urandom % 40);
            din = logic'($urandom % 2);
            cut = logic'(($urandom % 8) == 0);
            if (($urandom % 40) == 0) begin
                inj_s = 1'b1;
                inj_r = logic'($urandom % 2);
                tick();
                inj_s = 1'b0;
                inj_r = 1'b0;
            end
            for (int k = 0; k < len; k++) tick();
        end
        cut = 1'b0;

        // R9: reset clears the error flag
        rst = 1'b1;
        tick();
        chk("R9 err cleared", rx_err, 1'b0);
        chk("R9 dout cleared", rx_dout, 1'b0);
        rst = 1'b0;
        tick();

        summary();
        $finish;
    end

endmodule